// File: doc/BRIEF.md
# Bit-Field Extract/Insert Unit

This execution unit serves a 32-bit processor pipeline. Each cycle it looks at one instruction word together with a source operand and the present value of the destination register. It recognises two immediate bit-field operations that share one opcode group.

The **extract** form pulls a field of `width` bits out of the source, starting at bit `offset`. It returns that field right-justified and fills every bit above it with zero. The **insert** form takes the low `width` bits of the source and places them in the destination value starting at bit `offset`. All other destination bits pass through unchanged.

The insert form does not carry the width directly. Its width slot holds the position of the field's top bit, and the unit recovers the width from that value and the offset.

The result, the destination register index, a write-enable and an illegal-encoding flag are registered, so they appear one clock after the instruction is presented. Words outside the opcode group give no write and no flag. Encodings inside the group whose fields are out of range raise the flag and do not write.

Top module: `bitfield_unit`

## Requirements
- R1: A word is recognised only when (word & 0xFC00C000) equals 0x64004000 (extract) or 0x64008000 (insert). Any other word gives write-enable 0 and illegal flag 0 on the next cycle. Bits outside that mask have no effect.
- R2: Within the group, bits [15:14] = 01 select extract and 10 select insert. The values 00 and 11 are not recognised.
- R3: The offset is bits [4:0]. Bits [10:6] are the extract width or the insert top position. On a write, the destination index output equals bits [25:21] of the word.
- R4: A legal extract returns src[offset+width-1 : offset] in result bits [width-1:0], and every result bit at or above `width` is zero.
- R5: A legal insert returns the destination value with bits [top:offset] replaced by src[top-offset:0]. Every other bit equals the destination input.
- R6: Insert with offset 0 and top 31 is legal and returns the full source operand.
- R7: An extract with width 0, or with width + offset > 32, sets the illegal flag and clears write-enable.
- R8: An insert whose top position is below its offset sets the illegal flag and clears write-enable. Every other insert encoding is legal.
- R9: The outputs are registered with one cycle of latency. Synchronous active-high reset clears write-enable, the illegal flag, the result and the destination index.
- R10: Write-enable and the illegal flag are never both 1. In any cycle without a write, the result and the destination index keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Current destination register value |
| res_o | output | 32 | Registered result |
| rd_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered write-enable |
| illegal_o | output | 1 | Registered illegal-encoding flag |

## Verification
The assertions assume that every input is a defined value on each rising edge. They also assume that reset is held for at least one edge before any instruction is judged, because each property compares the outputs with the word seen one edge earlier.

The stimulus changes inputs only on falling edges and applies exactly one word per cycle. It sweeps every legal and every illegal pair of width and offset for both forms. It also randomises the operands and the bits the opcode mask ignores, so the single-cycle window assumed by the properties always holds.

// File: rtl/bitfield_unit.sv
`timescale 1ns/1ps
module bitfield_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] insn_i,
  input  logic [31:0] src_i,
  input  logic [31:0] dst_i,
  output logic [31:0] res_o,
  output logic [4:0]  rd_o,
  output logic        wr_en_o,
  output logic        illegal_o
);
  localparam logic [31:0] GRP_MASK = 32'hFC00C000;
  localparam logic [31:0] EXT_CODE = 32'h64004000;
  localparam logic [31:0] INS_CODE = 32'h64008000;

  logic        is_ext, is_ins, ext_ok, ins_ok, legal, bad;
  logic [4:0]  off, fld;
  logic [5:0]  ext_end;
  logic [32:0] wmask, top_mask;
  logic [31:0] low_mask, fmask, ext_val, ins_val;

  assign is_ext  = (insn_i & GRP_MASK) == EXT_CODE;
  assign is_ins  = (insn_i & GRP_MASK) == INS_CODE;
  assign off     = insn_i[4:0];
  assign fld     = insn_i[10:6];

  assign ext_end = {1'b0, fld} + {1'b0, off};
  assign ext_ok  = (fld != 5'd0) && (ext_end <= 6'd32);
  assign ins_ok  = fld >= off;
  assign legal   = (is_ext && ext_ok) || (is_ins && ins_ok);
  assign bad     = (is_ext && !ext_ok) || (is_ins && !ins_ok);

  assign wmask    = (33'd1 << fld) - 33'd1;
  assign ext_val  = (src_i >> off) & wmask[31:0];

  assign top_mask = (33'd1 << ({1'b0, fld} + 6'd1)) - 33'd1;
  assign low_mask = (32'd1 << off) - 32'd1;
  assign fmask    = top_mask[31:0] & ~low_mask;
  assign ins_val  = (dst_i & ~fmask) | ((src_i << off) & fmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      rd_o      <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wr_en_o   <= legal;
      illegal_o <= bad;
      if (legal) begin
        res_o <= is_ext ? ext_val : ins_val;
        rd_o  <= insn_i[25:21];
      end
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
`timescale 1ns/1ps
module bitfield_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] insn_i,
  input logic [31:0] src_i,
  input logic [31:0] dst_i,
  input logic [31:0] res_o,
  input logic [4:0]  rd_o,
  input logic        wr_en_o,
  input logic        illegal_o
);
  logic       grp_ext, grp_ins, ext_bad, ins_bad;
  logic [4:0] c_off, c_fld;

  assign grp_ext = insn_i[31:26] == 6'b011001 && insn_i[15:14] == 2'b01;
  assign grp_ins = insn_i[31:26] == 6'b011001 && insn_i[15:14] == 2'b10;
  assign c_off   = insn_i[4:0];
  assign c_fld   = insn_i[10:6];
  assign ext_bad = grp_ext && (c_fld == 5'd0 || (32'(c_fld) + 32'(c_off)) > 32);
  assign ins_bad = grp_ins && (c_fld < c_off);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_o && illegal_o));

  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
    (!grp_ext && !grp_ins) |=> (!wr_en_o && !illegal_o));

  a_r7_ext_flag: assert property (@(posedge clk) disable iff (rst)
    ext_bad |=> (illegal_o && !wr_en_o));

  a_r8_ins_flag: assert property (@(posedge clk) disable iff (rst)
    ins_bad |=> (illegal_o && !wr_en_o));

  a_r4_ext_zero_top: assert property (@(posedge clk) disable iff (rst)
    (grp_ext && !ext_bad) |=> (wr_en_o && (res_o >> $past(c_fld)) == 32'd0));

  a_r5_ins_keep_low: assert property (@(posedge clk) disable iff (rst)
    (grp_ins && !ins_bad && c_off != 5'd0) |=> (wr_en_o && res_o[0] == $past(dst_i[0])));

  a_r3_rd_index: assert property (@(posedge clk) disable iff (rst)
    (grp_ext || grp_ins) && !ext_bad && !ins_bad |=> rd_o == $past(insn_i[25:21]));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |-> ($stable(res_o) && $stable(rd_o)));
endmodule

bind bitfield_unit bitfield_unit_chk u_chk (.*);

// File: tb/test_bitfield_unit.sv
`timescale 1ns/1ps
module test_bitfield_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] insn_i, src_i, dst_i;
  logic [31:0] res_o;
  logic [4:0]  rd_o;
  logic        wr_en_o, illegal_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] e_res = '0;
  logic [4:0]  e_rd  = '0;
  logic        e_we  = 1'b0;
  logic        e_ill = 1'b0;

  always #5 clk = ~clk;

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rst(rst), .insn_i(insn_i), .src_i(src_i), .dst_i(dst_i),
    .res_o(res_o), .rd_o(rd_o), .wr_en_o(wr_en_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc(input logic [1:0] kind, input int rd, input int f, input int off);
    logic [31:0] w;
    w = $urandom();
    w[31:26] = 6'b011001;
    w[25:21] = rd[4:0];
    w[15:14] = kind;
    w[10:6]  = f[4:0];
    w[4:0]   = off[4:0];
    return w;
  endfunction

  task automatic compare(input string tag);
    n_vec++;
    if (res_o !== e_res || rd_o !== e_rd || wr_en_o !== e_we || illegal_o !== e_ill) begin
      n_bad++;
      $display("FAIL %s insn=%h: got res=%h rd=%0d we=%b ill=%b expected res=%h rd=%0d we=%b ill=%b",
               tag, insn_i, res_o, rd_o, wr_en_o, illegal_o, e_res, e_rd, e_we, e_ill);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] s, input logic [31:0] d, input string tag);
    int off, f, wd;
    bit ext, ins, ok;
    @(negedge clk);
    insn_i = w; src_i = s; dst_i = d;
    ext = (w[31:26] == 6'b011001) && (w[15:14] == 2'b01);
    ins = (w[31:26] == 6'b011001) && (w[15:14] == 2'b10);
    off = int'(w[4:0]);
    f   = int'(w[10:6]);
    ok  = 0;
    if (ext) begin
      wd = f;
      ok = (wd >= 1) && (wd + off <= 32);
      if (ok) for (int i = 0; i < 32; i++) e_res[i] = (i < wd) ? s[i + off] : 1'b0;
    end else if (ins) begin
      wd = f - off + 1;
      ok = (f >= off);
      if (ok) for (int i = 0; i < 32; i++) e_res[i] = (i >= off && i < off + wd) ? s[i - off] : d[i];
    end
    e_we  = ok;
    e_ill = (ext || ins) && !ok;
    if (ok) e_rd = w[25:21];
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  initial begin
    rst = 1'b1;
    insn_i = '0; src_i = '0; dst_i = '0;
    repeat (3) @(posedge clk);
    #2;
    compare("R9 reset");
    @(negedge clk);
    rst = 1'b0;

    apply(enc(2'b10, 7, 31, 0), 32'hDEADBEEF, 32'h12345678, "R6 full insert");
    apply(32'h00000000, 32'hFFFFFFFF, 32'h0, "R10 hold after write");
    apply(enc(2'b00, 3, 4, 2), 32'hFFFFFFFF, 32'h0, "R2 kind 00");
    apply(enc(2'b11, 3, 4, 2), 32'hFFFFFFFF, 32'h0, "R2 kind 11");
    apply(enc(2'b01, 9, 8, 4), 32'h00000AB0, 32'hFFFFFFFF, "R4 extract byte");
    apply(enc(2'b01, 9, 0, 4), 32'h1, 32'h1, "R7 width zero");
    apply(enc(2'b01, 9, 31, 2), 32'h1, 32'h1, "R7 overrun");
    apply(enc(2'b10, 9, 3, 4), 32'h1, 32'h1, "R8 top below offset");

    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      w = $urandom();
      if ((w & 32'hFC00C000) == 32'h64004000 || (w & 32'hFC00C000) == 32'h64008000) w[31] = 1'b1;
      apply(w, $urandom(), $urandom(), "R1 foreign word");
    end

    for (int wd = 1; wd <= 31; wd++)
      for (int off = 0; off + wd <= 32; off++)
        apply(enc(2'b01, $urandom_range(31), wd, off), $urandom(), $urandom(), "R4 R3 extract sweep");

    for (int off = 0; off < 32; off++)
      for (int top = off; top < 32; top++)
        apply(enc(2'b10, $urandom_range(31), top, off), $urandom(), $urandom(), "R5 R3 insert sweep");

    for (int off = 0; off < 32; off++) begin
      apply(enc(2'b01, 5, 0, off), $urandom(), $urandom(), "R7 extract width zero sweep");
      for (int wd = 33 - off; wd < 32; wd++)
        if (wd >= 1) apply(enc(2'b01, 5, wd, off), $urandom(), $urandom(), "R7 extract overrun sweep");
    end

    for (int off = 1; off < 32; off++)
      for (int top = 0; top < off; top++)
        apply(enc(2'b10, 6, top, off), $urandom(), $urandom(), "R8 insert reversed sweep");

    for (int k = 0; k < 500; k++) begin
      logic [1:0] kd;
      kd = $urandom_range(3);
      apply(enc(kd, $urandom_range(31), $urandom_range(31), $urandom_range(31)),
            $urandom(), $urandom(), "R2 R10 mixed stream");
    end

    @(negedge clk);
    rst = 1'b1;
    insn_i = enc(2'b01, 4, 4, 0);
    @(posedge clk);
    #2;
    e_res = '0; e_rd = '0; e_we = 1'b0; e_ill = 1'b0;
    compare("R9 reset mid-run");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule